// File: doc/BRIEF.md
# Decode-Error Interrupt Register Group

This block is a small set of memory-mapped registers that turns an address-decode error event into a level interrupt. A hardware strobe records the event in a sticky status flag. Software clears the flag by writing a one to it. A mask decides whether the flag reaches the interrupt pin.

The mask cannot be written directly. Software clears mask bits by writing ones to an enable alias and sets them by writing ones to a disable alias. Neither alias stores anything. A separate control register holds one bit that enables the bus error response; the logic that acts on that bit lies outside this block.

Accesses are whole 32-bit words on a simple bus with address, write enable, write data and a combinational read-data return. Each register is at a fixed byte offset:

| Offset | Register |
|--------|----------|
| 0x0 | control |
| 0x4 | status |
| 0x8 | mask |
| 0xC | enable alias |
| 0x10 | disable alias |

Top module: `decode_err_irq_regs`

## Requirements
- R1: After reset, the control register reads 0, the status register reads 0, the mask register reads 1 and `irqOut` is 0.
- R2: A one-cycle pulse on `errEvent` sets status bit 0, and the status register reads 1 from the next cycle on. While the mask bit is 1, `irqOut` stays 0.
- R3: A write to offset 0x4 clears each status bit whose write-data bit is 1. A status bit whose write-data bit is 0 is left unchanged.
- R4: When `errEvent` and a write of 1 to status bit 0 fall in the same cycle, status bit 0 ends up set.
- R5: A write to offset 0xC clears each mask bit whose write-data bit is 1 and leaves the other mask bits unchanged. Offset 0xC always reads 0.
- R6: A write to offset 0x10 sets each mask bit whose write-data bit is 1. Offset 0x10 always reads 0.
- R7: A write to offset 0x8 changes neither the mask nor `irqOut`.
- R8: `irqOut` is 1 exactly when some status bit is 1 and its mask bit is 0. It reflects a write or event in the cycle after the clock edge that captures it.
- R9: Bit 0 of the control register at offset 0x0 can be read and written. Bits 31:1 of the control register read 0.
- R10: Offsets that are not word-aligned or not listed read 0, and writes to them change no register. Examples are 0x14, 0x1, 0x5 and 0xD.
- R11: `busRdData` shows the addressed register in the same cycle that the address is presented, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W (12) | Byte address of the access |
| busWrEn | input | 1 | Write strobe for the current cycle |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for `busAddr`, combinational |
| errEvent | input | SRC_W (1) | Decode-error event pulse, one bit per source |
| irqOut | output | 1 | Level interrupt |

## Verification
Register writes and event pulses are captured on a rising edge. The new register contents and the new `irqOut` level are due in the cycle right after that edge.

Read data involves no register. It is due as soon as the address settles.

The bench drives each write or event at a falling edge and checks results one nanosecond after the following rising edge. It samples reads at a falling edge one nanosecond after changing the address, so no check lands on an edge.

Ignored writes (to the mask, to misaligned offsets and to unlisted offsets) are each followed by a readback of the registers they might have disturbed and a look at `irqOut`.

// File: rtl/decode_err_irq_pkg.sv
package decode_err_irq_pkg;

  localparam int OFF_CTL  = 'h00;
  localparam int OFF_STAT = 'h04;
  localparam int OFF_MASK = 'h08;
  localparam int OFF_EN   = 'h0C;
  localparam int OFF_DIS  = 'h10;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTL, SEL_STAT, SEL_MASK, SEL_EN, SEL_DIS
  } regSel_t;

  typedef struct packed {
    logic wrCtl;
    logic wrStat;
    logic wrEn;
    logic wrDis;
  } wrStrobe_t;

endpackage

// File: rtl/decode_err_irq_ctrl.sv
module decode_err_irq_ctrl
  import decode_err_irq_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output regSel_t           rdSel,
  output wrStrobe_t         wrStb
);

  logic aligned;
  assign aligned = (busAddr[1:0] == 2'b00);

  always_comb begin
    rdSel = SEL_NONE;
    if (aligned) begin
      if      (busAddr == ADDR_W'(OFF_CTL))  rdSel = SEL_CTL;
      else if (busAddr == ADDR_W'(OFF_STAT)) rdSel = SEL_STAT;
      else if (busAddr == ADDR_W'(OFF_MASK)) rdSel = SEL_MASK;
      else if (busAddr == ADDR_W'(OFF_EN))   rdSel = SEL_EN;
      else if (busAddr == ADDR_W'(OFF_DIS))  rdSel = SEL_DIS;
    end
  end

  // The mask has no write strobe: writes to it go nowhere.
  always_comb begin
    wrStb        = '0;
    wrStb.wrCtl  = busWrEn && (rdSel == SEL_CTL);
    wrStb.wrStat = busWrEn && (rdSel == SEL_STAT);
    wrStb.wrEn   = busWrEn && (rdSel == SEL_EN);
    wrStb.wrDis  = busWrEn && (rdSel == SEL_DIS);
  end

  // R10: at most one register is written per cycle, and none when the offset is misaligned
  assert_one_target_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wrStb) && (!aligned -> (wrStb == '0)));

  // R7: a write to the mask offset raises no strobe
  assert_mask_no_strobe_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && aligned && busAddr == ADDR_W'(OFF_MASK)) |-> (wrStb == '0));

endmodule

// File: rtl/decode_err_irq_dp.sv
module decode_err_irq_dp
  import decode_err_irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SRC_W  = 1,
  parameter int CTL_W  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         wrStb,
  input  regSel_t           rdSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic [SRC_W-1:0]  errEvent,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);

  logic [CTL_W-1:0] ctlQ;
  logic [SRC_W-1:0] statQ, statD;
  logic [SRC_W-1:0] maskQ, maskD;
  logic             irqQ;

  // One status bit and one mask bit per event source.
  for (genvar i = 0; i < SRC_W; i++) begin : g_src
    always_comb begin
      // An event in the same cycle overrides a write-one-to-clear.
      statD[i] = errEvent[i] | (statQ[i] & ~(wrStb.wrStat & wrData[i]));
      maskD[i] = maskQ[i];
      if (wrStb.wrEn  && wrData[i]) maskD[i] = 1'b0;
      if (wrStb.wrDis && wrData[i]) maskD[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlQ  <= '0;
      statQ <= '0;
      maskQ <= '1;
      irqQ  <= 1'b0;
    end else begin
      if (wrStb.wrCtl) ctlQ <= wrData[CTL_W-1:0];
      statQ <= statD;
      maskQ <= maskD;
      irqQ  <= |(statD & ~maskD);
    end
  end

  assign irqOut = irqQ;

  always_comb begin
    rdData = '0;
    case (rdSel)
      SEL_CTL:  rdData[CTL_W-1:0] = ctlQ;
      SEL_STAT: rdData[SRC_W-1:0] = statQ;
      SEL_MASK: rdData[SRC_W-1:0] = maskQ;
      default:  rdData = '0;
    endcase
  end

  // R2: an event leaves its status bit set in the following cycle
  assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    errEvent[0] |=> statQ[0]);

  // R4: an event beats a simultaneous write-one-to-clear
  assert_event_wins_R4: assert property (@(posedge clk) disable iff (!rstN)
    (errEvent[0] && wrStb.wrStat && wrData[0]) |=> statQ[0]);

  // R3: a write-one-to-clear with no event leaves the bit clear
  assert_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb.wrStat && wrData[0] && !errEvent[0]) |=> !statQ[0]);

  // R7: the mask moves only through the enable and disable aliases
  assert_mask_ro_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(wrStb.wrEn || wrStb.wrDis) |=> $stable(maskQ));

  // R8: the interrupt is never raised without a pending, unmasked status bit
  assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> ((statQ & ~maskQ) != '0));

  // R8: with no event and no write, the interrupt level holds
  assert_irq_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (errEvent == '0 && !wrStb.wrStat && !wrStb.wrEn && !wrStb.wrDis) |=> $stable(irqOut));

endmodule

// File: rtl/decode_err_irq_regs.sv
module decode_err_irq_regs
  import decode_err_irq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int SRC_W  = 1,
  parameter int CTL_W  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic [SRC_W-1:0]  errEvent,
  output logic              irqOut
);

  regSel_t   rdSel;
  wrStrobe_t wrStb;

  decode_err_irq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .rdSel   (rdSel),
    .wrStb   (wrStb)
  );

  decode_err_irq_dp #(.DATA_W(DATA_W), .SRC_W(SRC_W), .CTL_W(CTL_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .wrStb    (wrStb),
    .rdSel    (rdSel),
    .wrData   (busWrData),
    .errEvent (errEvent),
    .rdData   (busRdData),
    .irqOut   (irqOut)
  );

endmodule

// File: tb/decode_err_irq_regs_bench.sv
`timescale 1ns/1ps
module decode_err_irq_regs_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [0:0]  errEvent = '0;
  logic        irqOut;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  decode_err_irq_regs u_decode_err_irq_regs (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .errEvent(errEvent), .irqOut(irqOut)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk); #1;
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic busRead(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic pulseEvent();
    @(negedge clk);
    errEvent = 1'b1;
    @(posedge clk); #1;
    errEvent = 1'b0;
  endtask

  task automatic testReset();
    logic [31:0] v;
    busRead(12'h000, v); check("R1 ctl", v, 0);
    busRead(12'h004, v); check("R1 status", v, 0);
    busRead(12'h008, v); check("R1 mask", v, 1);
    check("R1 irq", {31'b0, irqOut}, 0);
  endtask

  task automatic testEventMasked();
    logic [31:0] v;
    pulseEvent();
    check("R2 irq masked", {31'b0, irqOut}, 0);
    busRead(12'h004, v); check("R2 status set", v, 1);
  endtask

  task automatic testEnable();
    logic [31:0] v;
    busWrite(12'h00C, 32'h0000_0000);
    busRead(12'h008, v); check("R5 zero bits keep mask", v, 1);
    check("R8 still masked", {31'b0, irqOut}, 0);
    busWrite(12'h00C, 32'h0000_0001);
    check("R8 irq after enable", {31'b0, irqOut}, 1);
    busRead(12'h008, v); check("R5 mask cleared", v, 0);
    busRead(12'h00C, v); check("R5 enable reads 0", v, 0);
  endtask

  task automatic testClear();
    logic [31:0] v;
    busWrite(12'h004, 32'h0000_0000);
    busRead(12'h004, v); check("R3 write 0 keeps", v, 1);
    busWrite(12'h004, 32'h0000_0001);
    check("R8 irq drops on clear", {31'b0, irqOut}, 0);
    busRead(12'h004, v); check("R3 status cleared", v, 0);
  endtask

  task automatic testCollision();
    logic [31:0] v;
    @(negedge clk);
    busAddr = 12'h004; busWrData = 32'h1; busWrEn = 1'b1; errEvent = 1'b1;
    @(posedge clk); #1;
    busWrEn = 1'b0; errEvent = 1'b0;
    check("R4 irq kept", {31'b0, irqOut}, 1);
    busRead(12'h004, v); check("R4 event wins", v, 1);
  endtask

  task automatic testDisable();
    logic [31:0] v;
    busWrite(12'h010, 32'h0000_0001);
    check("R8 irq drops on disable", {31'b0, irqOut}, 0);
    busRead(12'h008, v); check("R6 mask set", v, 1);
    busRead(12'h010, v); check("R6 disable reads 0", v, 0);
    busRead(12'h004, v); check("R6 status kept", v, 1);
  endtask

  task automatic testMaskReadOnly();
    logic [31:0] v;
    busWrite(12'h008, 32'h0000_0000);
    check("R7 irq unchanged", {31'b0, irqOut}, 0);
    busRead(12'h008, v); check("R7 mask unchanged", v, 1);
  endtask

  task automatic testCtl();
    logic [31:0] v;
    busWrite(12'h000, 32'hFFFF_FFFF);
    busRead(12'h000, v); check("R9 ctl bit0 only", v, 1);
    busWrite(12'h000, 32'hFFFF_FFFE);
    busRead(12'h000, v); check("R9 ctl cleared", v, 0);
    busWrite(12'h000, 32'h0000_0001);
  endtask

  task automatic testUnmapped();
    logic [31:0] v;
    busWrite(12'h014, 32'hFFFF_FFFF);
    busWrite(12'h005, 32'h0000_0001);
    busWrite(12'h00D, 32'h0000_0001);
    busWrite(12'h001, 32'h0000_0000);
    check("R10 irq unchanged", {31'b0, irqOut}, 0);
    busRead(12'h004, v); check("R10 status kept", v, 1);
    busRead(12'h008, v); check("R10 mask kept", v, 1);
    busRead(12'h000, v); check("R10 ctl kept", v, 1);
    busRead(12'h014, v); check("R10 unlisted reads 0", v, 0);
    busRead(12'h001, v); check("R10 misaligned reads 0", v, 0);
  endtask

  task automatic testCombRead();
    @(negedge clk);
    busAddr = 12'h008;
    #0.5 check("R11 mask same cycle", busRdData, 1);
    busAddr = 12'h004;
    #0.5 check("R11 status same cycle", busRdData, 1);
    busAddr = 12'h000;
    #0.5 check("R11 ctl same cycle", busRdData, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    testReset();
    testEventMasked();
    testEnable();
    testClear();
    testCollision();
    testDisable();
    testMaskReadOnly();
    testCtl();
    testUnmapped();
    testCombRead();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule